// File: doc/BRIEF.md
# Interleaved Scanline Fetcher and Pixel Serializer

This block produces the horizontal timing for one scanline of bitmap video and fills the active part of that line with pixels read from a memory it shares with a CPU. All sequencing advances on a pixel-clock enable. Each memory slot has a fixed number of pixel clocks and is split into two halves. The first half always belongs to the CPU. The second half belongs to the video fetcher when it needs a word. When the fetcher has no need, the CPU may use that half as well.

Each video access reads one 16-bit word. The word goes into a holding register and then into a shift register. The shift register sends out 1 or 2 bits per pixel, depending on a colour-depth select, as a 2-bit palette index. Outside the active region the index is the border colour input. The block also drives an active-low horizontal sync and registered active and border flags. These flags line up with the pixel index at the output.

The colour depth and the line's start address are captured at the first pixel clock of each line. The memory returns video read data for the fetcher to take at the next enabled pixel clock after the request.

Top module: `vidline_fetch`

## Requirements
- R1: A line lasts SYNC_CLKS+LBORD_CLKS+ACT_CLKS+RBORD_CLKS enabled pixel clocks (defaults 144+64+640+64 = 912). hsync_n is low for the first SYNC_CLKS of them and high for the rest. hsync_n, disp_act, disp_border and pix_idx are registered together, so after the enabled edge at line position h they all describe pixel h. Line position 0 is the first enabled pixel clock after reset.
- R2: disp_act is high for line positions SYNC_CLKS+LBORD_CLKS up to ACT_CLKS positions later. disp_border is high for the remaining positions that are neither sync nor active. At most one of sync (hsync_n low), active and border is indicated at a time.
- R3: Whenever disp_act is low, pix_idx equals the border_idx value sampled at that same edge.
- R4: With depth_sel=0 (one bit per pixel), each word covers 16 pixels. Bit 15 comes first, and pix_idx = {1'b0, bit}.
- R5: With depth_sel=1 (two bits per pixel), each word covers 8 pixels. Bits [15:14] come first, and pix_idx equals the bit pair.
- R6: depth_sel and start_addr are sampled at the enabled edge at line position 0. Changing them later in the line has no effect on that line's pixels or addresses.
- R7: The first video fetch of a line reads start_addr. Each further video fetch of the line reads the previous address plus one.
- R8: A slot is SLOT_CLKS enabled pixel clocks, and slot phase is line position modulo SLOT_CLKS. A memory request can occur only at phase 0 (CPU half) or phase SLOT_CLKS/2 (video half). At phase 0, cpu_gnt and mem_req equal cpu_req, mem_vid is 0, and mem_addr equals cpu_addr when granted.
- R9: Video fetches (mem_vid=1) occur only in the video half and only from PRE_SLOTS slots before the active region until the active region ends. A video fetch is always made in the first video half of that window. A video fetch takes priority over a CPU request in the same half. A video half without a video fetch grants cpu_req.
- R10: Read data is taken at the next enabled pixel clock after a video request. The next word is prefetched so that every active pixel has data in both depths.
- R11: While pix_en is low, no request or grant is issued and nothing advances.
- R12: After reset, hsync_n=1, disp_act=0, disp_border=0, pix_idx=0 and mem_req=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_en | input | 1 | Pixel-clock enable |
| depth_sel | input | 1 | 0 = one bit per pixel, 1 = two bits per pixel |
| start_addr | input | AW | Word address of the line's first pixels |
| border_idx | input | 2 | Palette index shown outside the active region |
| cpu_req | input | 1 | CPU access request |
| cpu_addr | input | AW | CPU access address |
| cpu_gnt | output | 1 | CPU access granted this clock |
| mem_req | output | 1 | Memory access this clock |
| mem_vid | output | 1 | Current access is a video fetch |
| mem_addr | output | AW | Memory address |
| mem_rdata | input | 16 | Video read data, valid at next enabled clock |
| hsync_n | output | 1 | Horizontal sync, active low |
| disp_act | output | 1 | Active display pixel |
| disp_border | output | 1 | Border pixel |
| pix_idx | output | 2 | Palette index of the current pixel |

## Verification
In the video half of a slot, a pending CPU request and a video fetch can fall on the same pixel clock. The bench holds cpu_req high or low from a pseudo-random sequence across every phase, so this collision arises many times inside and outside the fetch window. In each video half the bench requires either a video fetch with no CPU grant at the expected next address, or a CPU grant that matches the request. The bench also compares every active pixel against a word computed from the line's latched start address, in both depths and with gated enables, so an arbitration slip that starves the serializer shows up as wrong pixel data.

// File: rtl/vfs_pkg.sv
// Shared definitions for the scanline fetcher.
// Assumes: nothing beyond standard SystemVerilog.
package vfs_pkg;
    typedef enum logic {
        DEPTH_1BPP = 1'b0,
        DEPTH_2BPP = 1'b1
    } depth_e;
endpackage

// File: rtl/vfs_htimer.sv
// Horizontal position counter and region decode.
// Assumes: every region length and the line length are multiples of SLOT_CLKS,
// and LBORD_CLKS >= PRE_SLOTS*SLOT_CLKS.
module vfs_htimer #(
    parameter int SYNC_CLKS  = 144,
    parameter int LBORD_CLKS = 64,
    parameter int ACT_CLKS   = 640,
    parameter int RBORD_CLKS = 64,
    parameter int SLOT_CLKS  = 8,
    parameter int PRE_SLOTS  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pix_en,
    output logic line_start,
    output logic in_sync,
    output logic in_act,
    output logic in_win,
    output logic cpu_phase,
    output logic vid_phase,
    output logic hsync_n,
    output logic disp_act,
    output logic disp_border
);
    localparam int LINE    = SYNC_CLKS + LBORD_CLKS + ACT_CLKS + RBORD_CLKS;
    localparam int HW      = $clog2(LINE);
    localparam int SLG     = $clog2(SLOT_CLKS);
    localparam int ACT_BEG = SYNC_CLKS + LBORD_CLKS;
    localparam int ACT_END = ACT_BEG + ACT_CLKS;
    localparam int WIN_BEG = ACT_BEG - PRE_SLOTS * SLOT_CLKS;
    localparam logic [HW-1:0]  H_LAST  = HW'(LINE - 1);
    localparam logic [HW-1:0]  H_SYNC  = HW'(SYNC_CLKS);
    localparam logic [HW-1:0]  H_ABEG  = HW'(ACT_BEG);
    localparam logic [HW-1:0]  H_AEND  = HW'(ACT_END);
    localparam logic [HW-1:0]  H_WBEG  = HW'(WIN_BEG);
    localparam logic [SLG-1:0] PH_VID  = SLG'(SLOT_CLKS / 2);

    logic [HW-1:0] hpos;

    // Advance the line position once per enabled pixel clock.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hpos <= '0;
        else if (pix_en)
            hpos <= (hpos == H_LAST) ? '0 : hpos + HW'(1);
    end

    // Region and slot-phase decode of the current position.
    always_comb begin
        line_start = (hpos == '0);
        in_sync    = (hpos < H_SYNC);
        in_act     = (hpos >= H_ABEG) && (hpos < H_AEND);
        in_win     = (hpos >= H_WBEG) && (hpos < H_AEND);
        cpu_phase  = (hpos[SLG-1:0] == '0);
        vid_phase  = (hpos[SLG-1:0] == PH_VID);
    end

    // Register the region flags so they leave with the pixel of the same position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hsync_n     <= 1'b1;
            disp_act    <= 1'b0;
            disp_border <= 1'b0;
        end else if (pix_en) begin
            hsync_n     <= !in_sync;
            disp_act    <= in_act;
            disp_border <= !in_sync && !in_act;
        end
    end

    a_r2_regions_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({!hsync_n, disp_act, disp_border}));
    a_r1_sync_begins: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_en && line_start) |=> !hsync_n);
    a_r1_sync_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_en && hpos == H_SYNC) |=> hsync_n);
    a_r11_hold_still: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_en |=> $stable(hpos));
endmodule

// File: rtl/vfs_slotarb.sv
// Splits each memory slot into a CPU half and a video half, and tracks the video address.
// Assumes: the phase strobes come from the line timer, and room comes from the serializer.
module vfs_slotarb #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pix_en,
    input  logic          line_start,
    input  logic          cpu_phase,
    input  logic          vid_phase,
    input  logic          in_win,
    input  logic          room,
    input  logic [AW-1:0] start_addr,
    input  logic          cpu_req,
    input  logic [AW-1:0] cpu_addr,
    output logic          cpu_gnt,
    output logic          vid_go,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr
);
    logic [AW-1:0] vaddr;

    // Decide the owner of this half-slot: video first in its own half, CPU otherwise.
    always_comb begin
        vid_go   = pix_en && vid_phase && in_win && room;
        cpu_gnt  = pix_en && cpu_req && (cpu_phase || (vid_phase && !vid_go));
        mem_req  = vid_go || cpu_gnt;
        mem_addr = vid_go ? vaddr : cpu_addr;
    end

    // Load the line's start address, then step one word per video fetch.
    always_ff @(posedge clk) begin
        if (!rst_n)
            vaddr <= '0;
        else if (pix_en && line_start)
            vaddr <= start_addr;
        else if (vid_go)
            vaddr <= vaddr + AW'(1);
    end

    a_r9_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
        !(vid_go && cpu_gnt));
    a_r7_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (vid_go && !line_start) |=> (vaddr == $past(vaddr) + AW'(1)));
    a_r11_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_en |-> !mem_req);
endmodule

// File: rtl/vfs_shifter.sv
// Holding register plus pixel shift register; emits a palette index per enabled clock.
// Assumes: read data arrives at the enabled clock after the request, and at most
// one video request is outstanding.
module vfs_shifter #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pix_en,
    input  logic          line_start,
    input  logic          in_act,
    input  logic          depth_sel,
    input  logic [1:0]    border_idx,
    input  logic          vid_go,
    input  logic [DW-1:0] mem_rdata,
    output logic          room,
    output logic [1:0]    pix_idx
);
    import vfs_pkg::*;
    localparam int RW = $clog2(DW + 1);
    localparam logic [RW-1:0] PPW_1 = RW'(DW);
    localparam logic [RW-1:0] PPW_2 = RW'(DW / 2);

    depth_e        mode_q;
    logic [DW-1:0] sh, sh_n, hold, hold_n;
    logic [RW-1:0] rem, rem_n, ppw;
    logic          hold_v, hold_v_n, pend, take_hold;
    logic [1:0]    top;

    // Next state of shifter and holding register: consume first, then place arriving data.
    always_comb begin
        ppw       = (mode_q == DEPTH_2BPP) ? PPW_2 : PPW_1;
        top       = (mode_q == DEPTH_2BPP) ? sh[DW-1:DW-2] : {1'b0, sh[DW-1]};
        take_hold = in_act && (rem == RW'(1));
        sh_n      = sh;
        rem_n     = rem;
        hold_n    = hold;
        hold_v_n  = hold_v;
        if (take_hold) begin
            sh_n     = hold;
            rem_n    = ppw;
            hold_v_n = 1'b0;
        end else if (in_act) begin
            sh_n  = (mode_q == DEPTH_2BPP) ? (sh << 2) : (sh << 1);
            rem_n = rem - RW'(1);
        end
        if (pend) begin
            if (rem_n == '0) begin
                sh_n  = mem_rdata;
                rem_n = ppw;
            end else begin
                hold_n   = mem_rdata;
                hold_v_n = 1'b1;
            end
        end
        room = (rem == '0) || !hold_v;
    end

    // Update storage on each enabled clock; clear it and latch the depth at line start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= DEPTH_1BPP;
            sh     <= '0;
            hold   <= '0;
            rem    <= '0;
            hold_v <= 1'b0;
            pend   <= 1'b0;
        end else if (pix_en) begin
            pend <= vid_go;
            if (line_start) begin
                mode_q <= depth_e'(depth_sel);
                rem    <= '0;
                hold_v <= 1'b0;
            end else begin
                sh     <= sh_n;
                hold   <= hold_n;
                rem    <= rem_n;
                hold_v <= hold_v_n;
            end
        end
    end

    // Drive the palette index: shifted data in the active region, border colour elsewhere.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pix_idx <= '0;
        else if (pix_en)
            pix_idx <= in_act ? top : border_idx;
    end

    a_r10_no_underrun: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_en && in_act) |-> (rem != '0));
    a_r10_hold_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_en && take_hold) |-> hold_v);
    a_r10_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_en && pend && !line_start && (rem_n != '0)) |-> (!hold_v || take_hold));
endmodule

// File: rtl/vidline_fetch.sv
// Top level: line timer, slot arbiter and pixel serializer for one scanline.
// Assumes: mem_rdata holds a video word from the enabled clock after its request
// until the next enabled clock.
module vidline_fetch #(
    parameter int SYNC_CLKS  = 144,
    parameter int LBORD_CLKS = 64,
    parameter int ACT_CLKS   = 640,
    parameter int RBORD_CLKS = 64,
    parameter int SLOT_CLKS  = 8,
    parameter int PRE_SLOTS  = 2,
    parameter int AW         = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pix_en,
    input  logic          depth_sel,
    input  logic [AW-1:0] start_addr,
    input  logic [1:0]    border_idx,
    input  logic          cpu_req,
    input  logic [AW-1:0] cpu_addr,
    output logic          cpu_gnt,
    output logic          mem_req,
    output logic          mem_vid,
    output logic [AW-1:0] mem_addr,
    input  logic [15:0]   mem_rdata,
    output logic          hsync_n,
    output logic          disp_act,
    output logic          disp_border,
    output logic [1:0]    pix_idx
);
    localparam int DW = 16;

    logic line_start, in_sync, in_act, in_win, cpu_phase, vid_phase, room, vid_go;

    vfs_htimer #(
        .SYNC_CLKS(SYNC_CLKS), .LBORD_CLKS(LBORD_CLKS), .ACT_CLKS(ACT_CLKS),
        .RBORD_CLKS(RBORD_CLKS), .SLOT_CLKS(SLOT_CLKS), .PRE_SLOTS(PRE_SLOTS)
    ) u_timer (
        .clk(clk), .rst_n(rst_n), .pix_en(pix_en),
        .line_start(line_start), .in_sync(in_sync), .in_act(in_act), .in_win(in_win),
        .cpu_phase(cpu_phase), .vid_phase(vid_phase),
        .hsync_n(hsync_n), .disp_act(disp_act), .disp_border(disp_border)
    );

    vfs_slotarb #(.AW(AW)) u_arb (
        .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .line_start(line_start),
        .cpu_phase(cpu_phase), .vid_phase(vid_phase), .in_win(in_win), .room(room),
        .start_addr(start_addr), .cpu_req(cpu_req), .cpu_addr(cpu_addr),
        .cpu_gnt(cpu_gnt), .vid_go(vid_go), .mem_req(mem_req), .mem_addr(mem_addr)
    );

    vfs_shifter #(.DW(DW)) u_ser (
        .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .line_start(line_start),
        .in_act(in_act), .depth_sel(depth_sel), .border_idx(border_idx),
        .vid_go(vid_go), .mem_rdata(mem_rdata), .room(room), .pix_idx(pix_idx)
    );

    // Expose video ownership of the current access.
    always_comb mem_vid = vid_go;

    a_r9_no_fetch_in_sync: assert property (@(posedge clk) disable iff (!rst_n)
        mem_vid |-> !in_sync);
    a_r8_cpu_half_plain: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_en && cpu_phase) |-> (cpu_gnt == cpu_req) && !mem_vid);
endmodule

// File: tb/vidline_fetch_bench.sv
module vidline_fetch_bench;
    localparam int SY = 8, LB = 16, AC = 64, RB = 8, SL = 8, PRE = 2, AW = 12;
    localparam int LINE = SY + LB + AC + RB;
    localparam int AS = SY + LB, AE = AS + AC, WB = AS - PRE * SL, VPH = SL / 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0, pix_en = 1'b0, depth_sel = 1'b0, cpu_req = 1'b0;
    logic [AW-1:0] start_addr = '0, cpu_addr = '0;
    logic [1:0] border_idx = '0;
    logic cpu_gnt, mem_req, mem_vid, hsync_n, disp_act, disp_border;
    logic [AW-1:0] mem_addr;
    logic [15:0] mem_rdata = '0;
    logic [1:0] pix_idx;

    int nchk = 0, nerr = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    vidline_fetch #(.SYNC_CLKS(SY), .LBORD_CLKS(LB), .ACT_CLKS(AC), .RBORD_CLKS(RB),
        .SLOT_CLKS(SL), .PRE_SLOTS(PRE), .AW(AW)) u_vidline_fetch (
        .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .depth_sel(depth_sel),
        .start_addr(start_addr), .border_idx(border_idx), .cpu_req(cpu_req),
        .cpu_addr(cpu_addr), .cpu_gnt(cpu_gnt), .mem_req(mem_req), .mem_vid(mem_vid),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .hsync_n(hsync_n),
        .disp_act(disp_act), .disp_border(disp_border), .pix_idx(pix_idx));

    function automatic logic [15:0] wordf(input logic [AW-1:0] a);
        logic [31:0] p;
        p = {20'b0, a} * 32'h9E37;
        return p[15:0] ^ 16'h5AC3;
    endfunction

    // Memory model: video read data appears after the requesting edge.
    always @(posedge clk) if (mem_req && mem_vid) mem_rdata <= wordf(mem_addr);

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            nerr++; nchk++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        int hb = 0, hl = -1, lines = 0, vcnt = 0, cyc = 0, p;
        bit lmode = 1'b0, pe, saw_vid;
        logic [AW-1:0] lstart = '0;
        logic [1:0] bid_s = '0, expx;
        logic [15:0] w, lfsr = 16'hACE1;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R12 hsync_n", hsync_n, 1); chk("R12 disp_act", disp_act, 0);
        chk("R12 disp_border", disp_border, 0); chk("R12 pix_idx", pix_idx, 0);
        chk("R12 mem_req", mem_req, 0);
        @(posedge clk); #1;
        depth_sel = 1'b0; start_addr = 12'd5; border_idx = 2'd0; pix_en = 1'b1;
        while (lines < 8) begin
            @(negedge clk);
            // Registered outputs describe the last enabled position (R1, R2, R3, R4, R5)
            if (hl >= 0) begin
                chk("R1 hsync_n", hsync_n, hl >= SY);
                chk("R2 disp_act", disp_act, (hl >= AS && hl < AE));
                chk("R2 disp_border", disp_border, (hl >= SY && !(hl >= AS && hl < AE)));
                if (hl >= AS && hl < AE) begin
                    p = hl - AS;
                    if (lmode) begin
                        w = wordf(AW'(lstart + AW'(p / 8)));
                        expx = w[15 - 2 * (p % 8) -: 2];
                        chk("R5 pixel 2bpp", pix_idx, expx);
                    end else begin
                        w = wordf(AW'(lstart + AW'(p / 16)));
                        expx = {1'b0, w[15 - (p % 16)]};
                        chk("R4 pixel 1bpp", pix_idx, expx);
                    end
                end else
                    chk("R3 border colour", pix_idx, bid_s);
            end
            // Same-cycle request checks against the position about to be taken
            saw_vid = 1'b0;
            if (!pix_en) begin
                chk("R11 no request", mem_req, 0); chk("R11 no grant", cpu_gnt, 0);
            end else if (hb % SL == 0) begin
                chk("R8 cpu grant", cpu_gnt, cpu_req); chk("R8 cpu req", mem_req, cpu_req);
                chk("R8 not video", mem_vid, 0);
                if (cpu_req) chk("R8 cpu addr", mem_addr, cpu_addr);
            end else if (hb % SL == VPH) begin
                if (hb == WB + VPH) chk("R9 first window fetch", mem_vid, 1);
                if (mem_vid) begin
                    saw_vid = 1'b1;
                    chk("R9 fetch in window", (hb >= WB && hb < AE), 1);
                    chk("R9 video wins", cpu_gnt, 0);
                    chk("R7 video addr", mem_addr, AW'(lstart + AW'(vcnt)));
                end else begin
                    chk("R9 spare half to cpu", cpu_gnt, cpu_req);
                    chk("R9 spare half req", mem_req, cpu_req);
                    if (cpu_req) chk("R9 cpu addr", mem_addr, cpu_addr);
                end
            end else begin
                chk("R8 idle phase", mem_req, 0); chk("R8 idle grant", cpu_gnt, 0);
            end
            @(posedge clk);
            pe = pix_en;
            if (pe) begin
                if (hb == 0) begin
                    lmode = depth_sel; lstart = start_addr; vcnt = 0;
                end
                if (saw_vid) vcnt++;
                hl = hb; bid_s = border_idx;
                hb = (hb + 1) % LINE;
                if (hb == 0) lines++;
            end
            #1;
            cyc++;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (hb == 0) begin
                depth_sel = lines[0] ^ lines[2];
                start_addr = AW'(lines * 100 + 5);
                border_idx = 2'(lines);
            end else if (hb == 50) begin
                // R6: late changes must not affect this line
                depth_sel = ~depth_sel; start_addr = 12'hF00;
            end
            pix_en = (lines < 4) ? 1'b1 : (cyc % 3 != 2);
            cpu_req = lfsr[0];
            cpu_addr = lfsr[AW-1:0];
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule